// File: doc/BRIEF.md
# Four-Channel Input Capture Timer

A 16-bit up-counter with four independent input capture channels. The counter advances either once every four system clocks or once per rising edge of an external count pin, and only while its run bit is set. Each capture channel watches its own pin. When the selected edge condition is met, the channel copies the current count into its 16-bit capture register and raises its interrupt flag.

A mode bit decides what the first channel's register is for. In capture mode that register belongs to channel 1, and the counter runs freely through the whole 16-bit range. In period mode the same register holds the period that the counter restarts from zero at. Channel 1 stops capturing in that mode, and channels 2 to 4 carry on.

Software reaches the block through a byte-wide register port. Interrupt requests come out as flag-and-mask outputs. A channel marks an overflow when a new capture arrives before software has read the low byte of the previous one. Reading the low byte of the counter freezes its high byte in a holding latch, so a two-byte read returns one consistent 16-bit value.

Top module: `quad_capture_timer`

## Requirements
- R1: With run=1 and source=internal, the counter increments once every 4 clock cycles. With source=external, it increments once per rising edge of `ext_clk`, seen after a 2-flop synchronizer. With run=0 the counter holds.
- R2: In capture mode (mode bit=1), the counter goes from 0xFFFF to 0x0000 on the next count, and that wrap sets the timer flag (flag bit 0). The flag stays set until software writes 1 to it.
- R3: In period mode (mode bit=0), a count arriving while the counter equals the channel-1 register value loads 0 and sets the timer flag. In this mode channel 1 never captures.
- R4: A channel event copies the counter value into that channel's capture register and sets the channel's flag (flag bit k+1 for channel k, k=0..3). Channels 2 to 4 capture in both modes.
- R5: Each channel has a 2-bit edge field at bits [2k+1:2k] of register 1. The encodings are 00 = each falling edge, 01 = each rising edge, 10 = each 4th rising edge, 11 = each 16th rising edge. Any write to register 1 restarts all prescale counts.
- R6: A capture that arrives while the previous value is still unread sets that channel's overflow bit (register 4, bit k) and still stores the new value. Reading the channel's low byte marks the value as read.
- R7: When a capture and a software write hit the same capture register in the same cycle, the capture wins. Without a capture, software writes each byte directly.
- R8: Reading the counter low byte (register 5) latches the counter's high byte. Register 6 then returns that latched byte. Writing register 6 stages a high byte, and writing register 5 loads {staged, data} into the counter.
- R9: Flag register 2 and overflow register 4 are write-1-to-clear; a set in the same cycle wins. `irq[4:0]` equals flags AND mask (register 3).
- R10: The register map is: 0 = control, with bit0 run, bit1 source (1 = external) and bit2 mode. Addresses 8+2k and 9+2k are channel k's low and high capture bytes. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External count pin (asynchronous) |
| cap_pin | input | 4 | Capture input pins, one per channel (asynchronous) |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq | output | 5 | Masked interrupt requests: bit0 timer, bits 1..4 channels |

## Verification
The assertions take for granted that a read strobe and a write strobe never target the same capture low byte in one cycle. They also assume the external and capture pins stay at each level long enough to pass the two-flop synchronizer. The stimulus holds every pin level for at least four clocks. It issues exactly one bus operation at a time, driven between clock edges. The counter is stopped whenever exact captured values matter, so each expected value follows from the requirements alone.

// File: rtl/qct_pkg.sv
package qct_pkg;
  localparam int QCT_W  = 16;
  localparam int QCT_CH = 4;
  localparam int PRE_W  = 4;

  typedef logic [QCT_W-1:0] count_t;

  typedef enum logic [1:0] {
    EDGE_FALL   = 2'b00,
    EDGE_RISE   = 2'b01,
    EDGE_RISE4  = 2'b10,
    EDGE_RISE16 = 2'b11
  } edge_sel_e;

  function automatic logic [PRE_W:0] prescale_len(edge_sel_e m);
    case (m)
      EDGE_RISE4:  return (PRE_W+1)'(4);
      EDGE_RISE16: return (PRE_W+1)'(16);
      default:     return (PRE_W+1)'(1);
    endcase
  endfunction

  function automatic logic at_limit(count_t c, count_t period, logic period_mode);
    return period_mode ? (c == period) : (c == '1);
  endfunction

  function automatic count_t next_count(count_t c, logic hit);
    return hit ? '0 : c + 1'b1;
  endfunction
endpackage

// File: rtl/qct_timebase.sv
module qct_timebase
  import qct_pkg::*;
#(
  parameter int DIV_RATIO = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  logic   ext_sel,
  input  logic   ext_pin,
  input  logic   period_mode,
  input  count_t period,
  input  logic   load,
  input  count_t load_val,
  output count_t count,
  output logic   tick,
  output logic   wrap_evt
);
  localparam int DIV_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;

  logic [DIV_W-1:0] div_q;
  logic [2:0]       ext_sync;
  logic             ext_rise;
  logic             hit;

  assign ext_rise = ext_sync[1] & ~ext_sync[2];
  assign tick     = run & (ext_sel ? ext_rise : (div_q == DIV_W'(DIV_RATIO-1)));
  assign hit      = at_limit(count, period, period_mode);
  assign wrap_evt = tick & hit & ~load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      ext_sync <= '0;
      count    <= '0;
    end else begin
      ext_sync <= {ext_sync[1:0], ext_pin};
      if (!run || ext_sel || div_q == DIV_W'(DIV_RATIO-1)) div_q <= '0;
      else div_q <= div_q + 1'b1;
      if (load) count <= load_val;
      else if (tick) count <= next_count(count, hit);
    end
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count));
  assert_int_rate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ext_sel) |=> !tick);
  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !period_mode && count == '1) |=> (count == '0));
  assert_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && period_mode) |=> (count == '0));
endmodule

// File: rtl/qct_capture_ch.sv
module qct_capture_ch
  import qct_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin,
  input  logic      enable,
  input  edge_sel_e mode,
  input  logic      mode_wr,
  input  count_t    count,
  input  logic      wr_lo,
  input  logic      wr_hi,
  input  logic [7:0] wdata,
  input  logic      rd_lo,
  output count_t    cap,
  output logic      cap_evt,
  output logic      ovf_evt
);
  logic [2:0]       sync_q;
  logic             rise, fall, pre_wrap;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   pre_len;
  logic             unread_q;

  assign rise     = sync_q[1] & ~sync_q[2];
  assign fall     = ~sync_q[1] & sync_q[2];
  assign pre_len  = prescale_len(mode);
  assign pre_wrap = ({1'b0, pre_q} == pre_len - 1'b1);
  assign cap_evt  = enable & ((mode == EDGE_FALL) ? fall : (rise & pre_wrap));
  assign ovf_evt  = cap_evt & unread_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      pre_q    <= '0;
      unread_q <= 1'b0;
      cap      <= '0;
    end else begin
      sync_q <= {sync_q[1:0], pin};
      if (mode_wr) pre_q <= '0;
      else if (enable && rise && mode != EDGE_FALL) pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
      if (cap_evt) unread_q <= 1'b1;
      else if (rd_lo) unread_q <= 1'b0;
      if (cap_evt) cap <= count;
      else begin
        if (wr_lo) cap[7:0] <= wdata;
        if (wr_hi) cap[QCT_W-1:8] <= wdata;
      end
    end
  end

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap == $past(count)));
  assert_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && (wr_lo || wr_hi)) |=> (cap == $past(count)));
  assert_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> (sync_q[1] != sync_q[2]));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !cap_evt) |=> !ovf_evt);
endmodule

// File: rtl/quad_capture_timer.sv
module quad_capture_timer
  import qct_pkg::*;
#(
  parameter int DIV_RATIO = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_clk,
  input  logic [3:0] cap_pin,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic [4:0] irq
);
  localparam int NF = QCT_CH + 1;

  logic        run_q, ext_q, quad_q;
  logic [7:0]  edge_q;
  logic [NF-1:0] flag_q, mask_q;
  logic [QCT_CH-1:0] ovf_q;
  logic [7:0]  cnt_stage_q, cnt_hi_q;
  count_t      count;
  logic        tick, wrap_evt, cnt_load;
  logic [QCT_CH-1:0] cap_evt, ovf_evt;
  count_t      cap_val [QCT_CH];

  logic wr_ctrl, wr_edge, wr_flag, wr_mask, wr_ovf, wr_stage, rd_cnt_lo;

  assign wr_ctrl   = bus_wr && bus_addr == 4'd0;
  assign wr_edge   = bus_wr && bus_addr == 4'd1;
  assign wr_flag   = bus_wr && bus_addr == 4'd2;
  assign wr_mask   = bus_wr && bus_addr == 4'd3;
  assign wr_ovf    = bus_wr && bus_addr == 4'd4;
  assign cnt_load  = bus_wr && bus_addr == 4'd5;
  assign wr_stage  = bus_wr && bus_addr == 4'd6;
  assign rd_cnt_lo = bus_rd && bus_addr == 4'd5;

  qct_timebase #(.DIV_RATIO(DIV_RATIO)) u_tb (
    .clk, .rst_n, .run(run_q), .ext_sel(ext_q), .ext_pin(ext_clk),
    .period_mode(~quad_q), .period(cap_val[0]), .load(cnt_load),
    .load_val({cnt_stage_q, bus_wdata}), .count, .tick, .wrap_evt
  );

  for (genvar k = 0; k < QCT_CH; k++) begin : g_ch
    logic sel_lo, sel_hi;
    assign sel_lo = bus_addr == 4'(8 + 2*k);
    assign sel_hi = bus_addr == 4'(9 + 2*k);
    qct_capture_ch u_ch (
      .clk, .rst_n, .pin(cap_pin[k]),
      .enable((k == 0) ? quad_q : 1'b1),
      .mode(edge_sel_e'(edge_q[2*k +: 2])), .mode_wr(wr_edge),
      .count, .wr_lo(bus_wr && sel_lo), .wr_hi(bus_wr && sel_hi),
      .wdata(bus_wdata), .rd_lo(bus_rd && sel_lo),
      .cap(cap_val[k]), .cap_evt(cap_evt[k]), .ovf_evt(ovf_evt[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {run_q, ext_q, quad_q} <= '0;
      edge_q      <= '0;
      flag_q      <= '0;
      mask_q      <= '0;
      ovf_q       <= '0;
      cnt_stage_q <= '0;
      cnt_hi_q    <= '0;
    end else begin
      if (wr_ctrl) {quad_q, ext_q, run_q} <= bus_wdata[2:0];
      if (wr_edge) edge_q <= bus_wdata;
      if (wr_mask) mask_q <= bus_wdata[NF-1:0];
      if (wr_stage) cnt_stage_q <= bus_wdata;
      if (rd_cnt_lo) cnt_hi_q <= count[QCT_W-1:8];
      flag_q <= (flag_q & ~(wr_flag ? bus_wdata[NF-1:0] : '0)) | {cap_evt, wrap_evt};
      ovf_q  <= (ovf_q & ~(wr_ovf ? bus_wdata[QCT_CH-1:0] : '0)) | ovf_evt;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[3]) begin
      bus_rdata = bus_addr[0] ? cap_val[bus_addr[2:1]][QCT_W-1:8]
                              : cap_val[bus_addr[2:1]][7:0];
    end else begin
      case (bus_addr[2:0])
        3'd0: bus_rdata = {5'b0, quad_q, ext_q, run_q};
        3'd1: bus_rdata = edge_q;
        3'd2: bus_rdata = 8'(flag_q);
        3'd3: bus_rdata = 8'(mask_q);
        3'd4: bus_rdata = 8'(ovf_q);
        3'd5: bus_rdata = count[7:0];
        3'd6: bus_rdata = cnt_hi_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = flag_q & mask_q;

  assert_ch1_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !quad_q |-> !cap_evt[0]);
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && !(wr_flag && bus_wdata[0])) |=> flag_q[0]);
  assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt[1] |=> ovf_q[1]);
endmodule

// File: tb/quad_capture_timer_test.sv
module quad_capture_timer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0, ext_clk = 0;
  logic [3:0] cap_pin = 0, bus_addr = 0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [4:0] irq;
  int checks = 0, fails = 0;
  bit done = 0;

  quad_capture_timer uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr(4'd6, v[15:8]); wr(4'd5, v[7:0]);
  endtask

  task automatic get16(input logic [3:0] lo_addr, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo_addr, l); rd(lo_addr + 4'd1, h); v = {h, l};
  endtask

  task automatic ext_pulse();
    ext_clk = 1; repeat (4) @(posedge clk);
    ext_clk = 0; repeat (4) @(posedge clk);
  endtask

  task automatic pin_pulse(input int k);
    cap_pin[k] = 1; repeat (6) @(posedge clk);
    cap_pin[k] = 0; repeat (6) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(4'd0, d); check("R10 ctrl reset", d, 0);
    rd(4'd5, d); check("R10 count reset", d, 0);
    check("R9 irq reset", irq, 0);
  endtask

  task automatic t_internal();
    logic [15:0] v, v2;
    set_cnt(16'h0000);
    wr(4'd0, 8'h05);
    repeat (399) @(posedge clk);
    wr(4'd0, 8'h04);
    get16(4'd5, v); check("R1 internal rate", v, 100);
    repeat (20) @(posedge clk);
    get16(4'd5, v2); check("R1 hold when stopped", v2, 100);
  endtask

  task automatic t_atomic();
    logic [7:0] l, h;
    set_cnt(16'hAB12);
    rd(4'd5, l);
    set_cnt(16'h3456);
    rd(4'd6, h);
    check("R8 latched high byte", {h, l}, 16'hAB12);
  endtask

  task automatic t_wrap();
    logic [15:0] v; logic [7:0] d;
    wr(4'd2, 8'h1F); wr(4'd3, 8'h01);
    set_cnt(16'hFFFE);
    wr(4'd0, 8'h07);
    ext_pulse();
    rd(4'd2, d); check("R2 no flag before wrap", d[0], 0);
    ext_pulse();
    wr(4'd0, 8'h06);
    get16(4'd5, v); check("R2 wrap to zero", v, 0);
    repeat (10) @(posedge clk);
    rd(4'd2, d); check("R2 flag sticky", d[0], 1);
    check("R9 irq timer", irq[0], 1);
    wr(4'd2, 8'h01);
    rd(4'd2, d); check("R9 write-1 clear", d[0], 0);
  endtask

  task automatic t_capture();
    logic [15:0] v; logic [7:0] d;
    wr(4'd0, 8'h04); wr(4'd1, 8'h55); wr(4'd2, 8'h1F); wr(4'd4, 8'h0F);
    set_cnt(16'h1234);
    pin_pulse(1);
    rd(4'd2, d); check("R4 channel 2 flag", d[2], 1);
    get16(4'd10, v); check("R4 capture value", v, 16'h1234);
    set_cnt(16'h2000); pin_pulse(1);
    rd(4'd4, d); check("R6 no overflow after read", d[1], 0);
    get16(4'd10, v);
    set_cnt(16'h3000); pin_pulse(1);
    set_cnt(16'h3001); pin_pulse(1);
    rd(4'd4, d); check("R6 overflow set", d[1], 1);
    get16(4'd10, v); check("R6 newest value kept", v, 16'h3001);
  endtask

  task automatic t_edges();
    logic [15:0] v; logic [7:0] d;
    wr(4'd1, 8'h85); wr(4'd2, 8'h1F);
    set_cnt(16'h0777);
    cap_pin[2] = 1; repeat (6) @(posedge clk);
    rd(4'd2, d); check("R5 falling mode ignores rise", d[3], 0);
    cap_pin[2] = 0; repeat (6) @(posedge clk);
    rd(4'd2, d); check("R5 falling mode captures", d[3], 1);
    get16(4'd12, v); check("R5 falling capture value", v, 16'h0777);
    for (int i = 0; i < 3; i++) pin_pulse(3);
    rd(4'd2, d); check("R5 divide-by-4 not yet", d[4], 0);
    pin_pulse(3);
    rd(4'd2, d); check("R5 divide-by-4 fires", d[4], 1);
    wr(4'd2, 8'h1F);
    pin_pulse(3); pin_pulse(3);
    wr(4'd1, 8'h85);
    for (int i = 0; i < 3; i++) pin_pulse(3);
    rd(4'd2, d); check("R5 prescale restarts on write", d[4], 0);
    wr(4'd1, 8'h87);
    for (int i = 0; i < 15; i++) pin_pulse(0);
    rd(4'd2, d); check("R5 divide-by-16 not yet", d[1], 0);
    pin_pulse(0);
    rd(4'd2, d); check("R5 divide-by-16 fires", d[1], 1);
  endtask

  task automatic t_priority();
    logic [15:0] v;
    wr(4'd1, 8'h55);
    wr(4'd10, 8'hAA);
    get16(4'd10, v); check("R7 plain software write", v[7:0], 8'hAA);
    set_cnt(16'h4444);
    @(negedge clk); cap_pin[1] = 1;
    @(posedge clk); @(posedge clk);
    wr(4'd10, 8'hAA);
    repeat (4) @(posedge clk);
    cap_pin[1] = 0; repeat (6) @(posedge clk);
    get16(4'd10, v); check("R7 capture beats write", v, 16'h4444);
  endtask

  task automatic t_period();
    logic [15:0] v; logic [7:0] d;
    wr(4'd0, 8'h02);
    wr(4'd8, 8'h05); wr(4'd9, 8'h00);
    set_cnt(16'h0000);
    wr(4'd2, 8'h1F);
    wr(4'd0, 8'h03);
    for (int i = 0; i < 5; i++) ext_pulse();
    get16(4'd5, v); check("R3 reaches period", v, 5);
    rd(4'd2, d); check("R3 no flag at period", d[0], 0);
    ext_pulse();
    get16(4'd5, v); check("R3 restarts at zero", v, 0);
    rd(4'd2, d); check("R3 flag on restart", d[0], 1);
    pin_pulse(0);
    rd(4'd2, d); check("R3 channel 1 off", d[1], 0);
    get16(4'd8, v); check("R3 period kept", v, 5);
    pin_pulse(1);
    rd(4'd2, d); check("R4 channel 2 in period mode", d[2], 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_internal();
    t_atomic();
    t_wrap();
    t_capture();
    t_edges();
    t_priority();
    t_period();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule